// File: doc/BRIEF.md
# Priority Memory Map Decoder

The block turns an address into one resolved chip select for a small memory complex. There are nine regions: SRAM, I/O, peripheral I/O, two secondary-flash sectors and four primary-flash sectors. Each region is described by two programmable product terms. Each term is a match value, a care mask and an enable bit. Several regions may claim the same address. A fixed three-tier ranking then decides the winner:
- SRAM, I/O and peripheral I/O rank highest.
- Secondary flash ranks next.
- Primary flash is the fallback.

The resolved select is produced combinationally from `addr_i`. A registered copy is also provided for paths that need timing slack.

Configuration is loaded through a word-wide write port. Every write restarts a background scan that visits each address once, one per clock. The scan looks for placement mistakes: two regions of the same tier claiming one address, or a flash region covering more addresses than its physical sector holds. `config_error_o` is updated only when the scan finishes. `scan_done_o` marks that the result is current.

Top module: `pmd_map_decoder`

## Requirements
- R1: After reset, all terms are disabled, `sel_o` and `sel_q_o` are zero, `scan_done_o` is 1 and `config_error_o` is 0.
- R2: A term hits when its enable is 1 and `(addr & mask) == (match & mask)`. A region matches when either of its two terms hits. A disabled term never matches, whatever its match and mask hold.
- R3: Select bit encoding is: bit0 SRAM, bit1 I/O, bit2 peripheral I/O, bit3..4 secondary sectors 0..1, bit5..8 primary sectors 0..3. A matching SRAM, I/O or peripheral I/O region wins over any flash match.
- R4: A matching secondary sector wins over any primary sector when no top-tier region matches.
- R5: `sel_o` has at most one bit set. It is all zero when no region matches.
- R6: `sel_q_o` equals the value `sel_o` had before the previous rising clock edge.
- R7: A write with `cfg_we_i` high takes effect at the next rising edge. `cfg_addr_i[6:2]` selects term 2*region+k, with k = 0 or 1. `cfg_addr_i[1:0]` selects the field: 0 for match, 1 for mask, 2 for enable (data bit 0).
- R8: A write drops `scan_done_o` after its clock edge. `scan_done_o` rises again exactly 2^ADDR_W rising edges after the last write.
- R9: At the end of a scan, `config_error_o` is 1 if any address was matched by two regions of the same tier.
- R10: At the end of a scan, `config_error_o` is 1 if a secondary region matched more than 2^SEC_SZ_LOG2 addresses, or a primary region more than 2^PRI_SZ_LOG2. Exactly the sector size is legal.
- R11: When regions of one tier overlap illegally, the one with the lowest select bit wins.
- R12: `config_error_o` holds its value while a scan runs. It changes only when a scan completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Address to decode |
| sel_o | output | 9 | Resolved one-hot select, combinational |
| sel_q_o | output | 9 | Registered copy of `sel_o` |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | Term index and field of the write |
| cfg_data_i | input | ADDR_W | Write data |
| scan_done_o | output | 1 | Placement scan complete, error flag current |
| config_error_o | output | 1 | Placement rule broken in the last completed scan |

## Verification
The bench sweeps every address of a 10-bit instance under several maps. These include the three-deep nested case, a full legal map, and deliberately illegal maps. A wrong tier order would surface as secondary or primary selects inside the nested SRAM window. A sector check that is off by one would either flag a region of exactly sector size or miss a region one size larger. Writing an enable of 0 while match and mask still fit the address catches a decoder that ignores the enable. Watching the error flag through a running scan catches a flag that changes before the scan ends. Counting edges from the last write to the rise of the done flag catches a scan that skips or repeats addresses.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int NREG   = 9;
  localparam int NTPR   = 2;
  localparam int NTERM  = NREG * NTPR;
  localparam int TIDX_W = $clog2(NTERM);
  localparam int CFG_AW = TIDX_W + 2;
  // select bit positions; tier order fixed by position
  localparam int R_SRAM = 0;
  localparam int R_SEC0 = 3;
  localparam int R_PRI0 = 5;
  localparam int N_T1   = 3;
  localparam int N_SEC  = 2;
  localparam int N_PRI  = 4;
  typedef enum logic [1:0] {
    F_MATCH = 2'd0,
    F_MASK  = 2'd1,
    F_EN    = 2'd2
  } cfg_field_e;
endpackage

// File: rtl/pmd_region_match.sv
module pmd_region_match
  import pmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NTERM-1:0][ADDR_W-1:0]  match_i,
  input  logic [NTERM-1:0][ADDR_W-1:0]  mask_i,
  input  logic [NTERM-1:0]              en_i,
  output logic [NREG-1:0]               hit_o
);
  logic [NTERM-1:0] term_hit;

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    assign term_hit[t] = en_i[t] && ((addr_i & mask_i[t]) == (match_i[t] & mask_i[t]));
  end

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign hit_o[r] = |term_hit[r*NTPR +: NTPR];
  end
endmodule

// File: rtl/pmd_resolve.sv
module pmd_resolve
  import pmd_pkg::*;
(
  input  logic [NREG-1:0] hit_i,
  output logic [NREG-1:0] sel_o
);
  logic [N_T1-1:0]  t1;
  logic [N_SEC-1:0] t2;
  logic [N_PRI-1:0] t3;

  always_comb begin
    t1 = '0;
    t2 = '0;
    t3 = '0;
    for (int i = N_T1 - 1; i >= 0; i--)
      if (hit_i[R_SRAM+i]) t1 = N_T1'(1) << i;
    for (int i = N_SEC - 1; i >= 0; i--)
      if (hit_i[R_SEC0+i]) t2 = N_SEC'(1) << i;
    for (int i = N_PRI - 1; i >= 0; i--)
      if (hit_i[R_PRI0+i]) t3 = N_PRI'(1) << i;
    sel_o = '0;
    if (|t1)      sel_o[R_SRAM +: N_T1]  = t1;
    else if (|t2) sel_o[R_SEC0 +: N_SEC] = t2;
    else          sel_o[R_PRI0 +: N_PRI] = t3;
  end
endmodule

// File: rtl/pmd_scan.sv
module pmd_scan
  import pmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SEC_SZ_LOG2 = 13,
  parameter int PRI_SZ_LOG2 = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NREG-1:0]   hit_i,
  output logic [ADDR_W-1:0] scan_addr_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int NFL = N_SEC + N_PRI;
  localparam logic [ADDR_W:0] SEC_LIM = (ADDR_W+1)'(1) << SEC_SZ_LOG2;
  localparam logic [ADDR_W:0] PRI_LIM = (ADDR_W+1)'(1) << PRI_SZ_LOG2;
  localparam logic [ADDR_W-1:0] A_LAST = '1;

  logic                run_q, acc_q;
  logic [ADDR_W:0]     cnt_q [NFL];
  logic                ovl, over, bad;

  always_comb begin
    ovl = ($countones(hit_i[R_SRAM +: N_T1]) > 1) ||
          ($countones(hit_i[R_SEC0 +: N_SEC]) > 1) ||
          ($countones(hit_i[R_PRI0 +: N_PRI]) > 1);
    over = 1'b0;
    for (int j = 0; j < NFL; j++)
      if (hit_i[R_SEC0+j] && cnt_q[j] == ((j < N_SEC) ? SEC_LIM : PRI_LIM)) over = 1'b1;
    bad = ovl || over;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      acc_q       <= 1'b0;
      err_o       <= 1'b0;
      scan_addr_o <= '0;
      for (int j = 0; j < NFL; j++) cnt_q[j] <= '0;
    end else if (start_i) begin
      run_q       <= 1'b1;
      acc_q       <= 1'b0;
      scan_addr_o <= '0;
      for (int j = 0; j < NFL; j++) cnt_q[j] <= '0;
    end else if (run_q) begin
      scan_addr_o <= scan_addr_o + 1'b1;
      acc_q       <= acc_q | bad;
      for (int j = 0; j < NFL; j++)
        if (hit_i[R_SEC0+j]) cnt_q[j] <= cnt_q[j] + 1'b1;
      if (scan_addr_o == A_LAST) begin
        run_q <= 1'b0;
        err_o <= acc_q | bad;
      end
    end
  end

  assign done_o = ~run_q;

  // R8
  scan_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o && scan_addr_o == '0);
  // R12
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(err_o) || $rose(done_o));
  // R8
  scan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !start_i && scan_addr_o != A_LAST |=> scan_addr_o != '0);
endmodule

// File: rtl/pmd_map_decoder.sv
module pmd_map_decoder
  import pmd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SEC_SZ_LOG2 = 13,
  parameter int PRI_SZ_LOG2 = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o,
  output logic [NREG-1:0]   sel_q_o,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  output logic              scan_done_o,
  output logic              config_error_o
);
  logic [NTERM-1:0][ADDR_W-1:0] match_q, mask_q;
  logic [NTERM-1:0]             en_q;
  logic [NREG-1:0]              hit, scan_hit;
  logic [ADDR_W-1:0]            scan_addr;
  logic [TIDX_W-1:0]            widx;
  cfg_field_e                   wfld;

  assign widx = cfg_addr_i[CFG_AW-1:2];
  assign wfld = cfg_field_e'(cfg_addr_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '0;
      mask_q  <= '0;
      en_q    <= '0;
    end else if (cfg_we_i && 32'(widx) < NTERM) begin
      case (wfld)
        F_MATCH: match_q[widx] <= cfg_data_i;
        F_MASK:  mask_q[widx]  <= cfg_data_i;
        F_EN:    en_q[widx]    <= cfg_data_i[0];
        default: ;
      endcase
    end
  end

  pmd_region_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_i(addr_i), .match_i(match_q), .mask_i(mask_q), .en_i(en_q), .hit_o(hit)
  );

  pmd_resolve u_res (.hit_i(hit), .sel_o(sel_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q_o <= '0;
    else         sel_q_o <= sel_o;
  end

  pmd_region_match #(.ADDR_W(ADDR_W)) u_scan_match (
    .addr_i(scan_addr), .match_i(match_q), .mask_i(mask_q), .en_i(en_q), .hit_o(scan_hit)
  );

  pmd_scan #(
    .ADDR_W(ADDR_W), .SEC_SZ_LOG2(SEC_SZ_LOG2), .PRI_SZ_LOG2(PRI_SZ_LOG2)
  ) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(cfg_we_i), .hit_i(scan_hit),
    .scan_addr_o(scan_addr), .done_o(scan_done_o), .err_o(config_error_o)
  );

  // R3
  top_tier_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit[R_SRAM +: N_T1]) |-> (sel_o[R_SEC0 +: N_SEC + N_PRI] == '0));
  // R4
  sec_over_pri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit[R_SEC0 +: N_SEC]) && !(|hit[R_SRAM +: N_T1]) |-> (sel_o[R_PRI0 +: N_PRI] == '0) && (|sel_o[R_SEC0 +: N_SEC]));
  // R5
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o) && ((hit == '0) == (sel_o == '0)));
  // R2
  sel_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o & ~hit) == '0);
endmodule

// File: tb/sim_pmd_map_decoder.sv
`timescale 1ns/1ps
module sim_pmd_map_decoder;
  localparam int AW = 10;
  localparam int NA = 1 << AW;
  localparam int SECL = 7;
  localparam int PRIL = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [8:0]    sel, sel_q;
  logic          we = 1'b0;
  logic [6:0]    caddr = '0;
  logic [AW-1:0] cdata = '0;
  logic          done, err;

  int n_run = 0, n_fail = 0;
  bit m_v [9][2];
  int m_lo [9][2];
  int m_hi [9][2];

  always #2.5 clk = ~clk;

  pmd_map_decoder #(.ADDR_W(AW), .SEC_SZ_LOG2(SECL), .PRI_SZ_LOG2(PRIL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .sel_o(sel), .sel_q_o(sel_q),
    .cfg_we_i(we), .cfg_addr_i(caddr), .cfg_data_i(cdata),
    .scan_done_o(done), .config_error_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // tiered model, lowest index wins inside a tier (R11)
  function automatic logic [8:0] exp_sel(input int a);
    logic [8:0] h;
    h = '0;
    for (int r = 0; r < 9; r++)
      for (int k = 0; k < 2; k++)
        if (m_v[r][k] && a >= m_lo[r][k] && a <= m_hi[r][k]) h[r] = 1'b1;
    for (int r = 0; r < 3; r++) if (h[r]) return 9'(1) << r;
    for (int r = 3; r < 5; r++) if (h[r]) return 9'(1) << r;
    for (int r = 5; r < 9; r++) if (h[r]) return 9'(1) << r;
    return '0;
  endfunction

  task automatic wr(input int term, input int fld, input int data);
    @(negedge clk);
    we = 1'b1; caddr = 7'((term << 2) | fld); cdata = AW'(data);
    @(posedge clk); #1;
    chk(!done, "R8 done low after write", 32'(done), 0);
    we = 1'b0;
  endtask

  task automatic set_region(input int r, input int k, input int base, input int size);
    wr(2*r+k, 0, base);
    wr(2*r+k, 1, (~(size-1)) & (NA-1));
    wr(2*r+k, 2, 1);
    m_v[r][k] = 1'b1; m_lo[r][k] = base; m_hi[r][k] = base + size - 1;
  endtask

  task automatic set_off(input int r, input int k);
    wr(2*r+k, 2, 0);
    m_v[r][k] = 1'b0;
  endtask

  task automatic clear_all();
    for (int r = 0; r < 9; r++)
      for (int k = 0; k < 2; k++) set_off(r, k);
  endtask

  task automatic wait_scan(input bit exp_err, input string req, input bit chk_len);
    int n;
    bit e0, moved;
    n = 0; e0 = err; moved = 1'b0;
    while (!done) begin
      @(posedge clk); #1;
      n++;
      if (!done && err != e0) moved = 1'b1;
    end
    chk(!moved, "R12 error held during scan", 32'(moved), 0);
    if (chk_len) chk(n == NA, "R8 scan length", n, NA);
    chk(err == exp_err, req, 32'(err), 32'(exp_err));
  endtask

  task automatic sweep(input string req);
    logic [8:0] prev;
    prev = '0;
    for (int i = 0; i <= NA; i++) begin
      @(negedge clk);
      if (i > 0) chk(sel_q == prev, "R6 registered select", 32'(sel_q), 32'(prev));
      if (i < NA) begin
        addr = AW'(i); #1;
        prev = exp_sel(i);
        chk(sel == prev, req, 32'(sel), 32'(prev));
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    addr = AW'(12'h205);
    #12; #1;
    // R1
    chk(sel == '0 && sel_q == '0, "R1 reset selects", 32'(sel), 0);
    chk(done && !err, "R1 reset scan state", {30'd0, done, err}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel == '0, "R1 R5 all disabled", 32'(sel), 0);

    // R7: enable write changes select only after its edge
    wr(0, 0, 'h200); wr(0, 1, 'h3e0);
    @(negedge clk); addr = AW'('h205);
    we = 1'b1; caddr = 7'(2); cdata = AW'(1); #1;
    chk(sel == '0, "R7 before edge", 32'(sel), 0);
    @(posedge clk); #1; we = 1'b0;
    chk(sel == 9'h001, "R7 after edge", 32'(sel), 1);
    m_v[0][0] = 1'b1; m_lo[0][0] = 'h200; m_hi[0][0] = 'h21f;

    // nested reference case: R3 R4 R5
    set_region(5, 0, 'h200, 'h100);
    set_region(3, 0, 'h200, 'h080);
    wait_scan(1'b0, "R9 legal nested map", 1'b1);
    sweep("R3 R4 R5 nested map");

    // full legal map, second SRAM term (R2)
    set_region(0, 1, 'h380, 'h020);
    set_region(1, 0, 'h000, 'h010);
    set_region(2, 0, 'h010, 'h010);
    set_region(4, 0, 'h300, 'h080);
    set_region(6, 0, 'h000, 'h100);
    set_region(7, 0, 'h100, 'h100);
    set_region(8, 0, 'h300, 'h100);
    wait_scan(1'b0, "R9 R10 legal full map", 1'b0);
    sweep("R2 R3 R4 full map");

    // top-tier overlap: R9 R11
    set_region(1, 1, 'h200, 'h010);
    wait_scan(1'b1, "R9 top tier overlap", 1'b0);
    sweep("R11 top tier overlap resolve");
    // disabled term keeps match/mask but must not hit (R2)
    set_off(1, 1);
    wait_scan(1'b0, "R9 overlap removed", 1'b0);
    @(negedge clk); addr = AW'('h205); #1;
    chk(sel == 9'h001, "R2 disabled term ignored", 32'(sel), 1);
    @(negedge clk); addr = AW'('h208); #1;
    chk(sel == 9'h001, "R2 disabled term ignored", 32'(sel), 1);

    // oversize: R10
    clear_all();
    set_region(4, 0, 'h000, 'h100);
    wait_scan(1'b1, "R10 secondary oversize", 1'b0);
    set_region(4, 0, 'h000, 'h080);
    wait_scan(1'b0, "R10 secondary exact size", 1'b0);
    set_region(5, 0, 'h200, 'h200);
    wait_scan(1'b1, "R10 primary oversize", 1'b0);
    set_region(5, 0, 'h200, 'h100);
    wait_scan(1'b0, "R10 primary exact size", 1'b0);
    sweep("R5 sparse map");

    // secondary overlap: R9 R11
    set_region(3, 0, 'h000, 'h080);
    set_region(4, 0, 'h040, 'h040);
    wait_scan(1'b1, "R9 secondary overlap", 1'b0);
    sweep("R11 secondary overlap resolve");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule